// File: doc/BRIEF.md
# Counting Semaphore Wait/Signal Unit

This block keeps a small bank of counting semaphores and serves WAIT and SIGNAL requests from several requesters, such as cores or hardware threads. Each requester holds a request line together with an operation bit and a semaphore index until it receives a one-cycle acknowledge. The acknowledge carries a response bit that says whether the operation was granted or the requester was put to sleep.

A WAIT on a non-zero count takes one unit from it and is granted. A WAIT on a zero count leaves the count alone, refuses the requester and marks it asleep on that semaphore. While it sleeps, its request line is ignored, and its pending WAIT is served again once it is woken. A SIGNAL adds one unit, saturating at the count maximum, and wakes every requester sleeping on that semaphore. One request is served per clock. A rotating pointer picks among the eligible requesters, so the order of retries follows the requester ring and not how long anyone has waited. Every read-modify-write of a count completes inside a single clock edge, so no other operation can interleave with it.

The parameters are the requester count `N_REQ` (at least 2), the semaphore count `N_SEM` (a power of two, at least 2), the count width `CNT_W` and the reset count `INIT_CNT`.

Top module: `sem_wait_signal_unit`

## Requirements
- R1: Synchronous reset sets every count to `INIT_CNT`, clears every sleep mark and the rotating pointer, and holds `ack` and `granted` at 0.
- R2: A served WAIT whose addressed count is non-zero decrements that count by one and returns `ack`=1 with `granted`=1.
- R3: A served WAIT whose addressed count is zero leaves the count unchanged, returns `ack`=1 with `granted`=0, and marks the requester asleep on that semaphore.
- R4: A sleeping requester is never acknowledged, whatever its request lines hold, until a SIGNAL on the semaphore it sleeps on has been served.
- R5: A served SIGNAL (`req_op`=1) increments the addressed count, returns `granted`=1, and clears the sleep mark of every requester sleeping on that semaphore and of no other.
- R6: A SIGNAL on a count at its maximum (all `CNT_W` bits set) leaves it at the maximum.
- R7: At most one requester is acknowledged per clock, and only a requester whose `req_valid` was high at the serving edge.
- R8: Among the eligible requesters, the one served is the first found starting at the pointer and moving up in index, wrapping from `N_REQ-1` to 0. After serving requester k, the pointer moves to k+1, wrapping to 0.
- R9: `ack` is a one-cycle pulse one clock after the serving edge. A requester acknowledged in a cycle is not eligible at the next edge, so it cannot be acknowledged in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_REQ | Request line per requester, held until acknowledged |
| req_op | input | N_REQ | Operation per requester: 0 = WAIT, 1 = SIGNAL |
| req_sem | input | N_REQ*$clog2(N_SEM) | Semaphore index per requester; requester r uses bits [r*W +: W] |
| ack | output | N_REQ | Registered one-cycle acknowledge per requester |
| granted | output | N_REQ | Response valid with `ack`: 1 = granted, 0 = refused and asleep |

## Verification
A count that is off by one shows up at the ports as a WAIT that is granted or refused against expectation, but only when a WAIT next reaches that semaphore. The stimulus therefore keeps draining counts to zero and pushing one count to saturation. A sleep mark that is stuck, lost or attached to the wrong semaphore shows up as a missing or extra acknowledge in the cycles that follow the relevant SIGNAL. A pointer that advances wrongly shows up at the first edge where two requests compete, so simultaneous requests from all requesters are applied on purpose.

// File: rtl/sem_unit_pkg.sv
package sem_unit_pkg;
  typedef enum logic {
    OP_WAIT   = 1'b0,
    OP_SIGNAL = 1'b1
  } sem_op_e;
endpackage

// File: rtl/sem_rr_arbiter.sv
module sem_rr_arbiter #(
  parameter int N = 4,
  localparam int IDW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   elig,
  output logic           win_vld,
  output logic [IDW-1:0] win_id
);
  logic [IDW-1:0] ptr_q;
  int pos;

  // first eligible requester at or above the pointer, wrapping around
  always_comb begin
    win_vld = 1'b0;
    win_id  = '0;
    pos     = 0;
    for (int i = 0; i < N; i++) begin
      pos = int'(ptr_q) + i;
      if (pos >= N) pos = pos - N;
      if (!win_vld && elig[pos]) begin
        win_vld = 1'b1;
        win_id  = IDW'(pos);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (win_vld) begin
      ptr_q <= (win_id == IDW'(N - 1)) ? '0 : win_id + 1'b1;
    end
  end
endmodule

// File: rtl/sem_count_bank.sv
module sem_count_bank #(
  parameter int N_SEM    = 4,
  parameter int CNT_W    = 4,
  parameter int INIT_CNT = 1,
  localparam int SIW = $clog2(N_SEM)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_en,
  input  logic           op_sig,
  input  logic [SIW-1:0] op_idx,
  output logic           op_ok
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(INIT_CNT);

  logic [CNT_W-1:0] cnt_q [N_SEM];
  logic [CNT_W-1:0] cur;
  logic [CNT_W-1:0] nxt;
  logic             nonzero;

  // test and update of one count happen in the same cycle: one atomic step
  always_comb begin
    cur     = cnt_q[op_idx];
    nonzero = (cur != '0);
    op_ok   = op_sig | nonzero;
    if (op_sig) begin
      nxt = (cur == CNT_MAX) ? cur : cur + 1'b1;
    end else begin
      nxt = nonzero ? cur - 1'b1 : cur;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < N_SEM; s++) cnt_q[s] <= CNT_INIT;
    end else if (op_en) begin
      cnt_q[op_idx] <= nxt;
    end
  end
endmodule

// File: rtl/sem_sleep_tracker.sv
module sem_sleep_tracker #(
  parameter int N_REQ = 4,
  parameter int N_SEM = 4,
  localparam int IDW = $clog2(N_REQ),
  localparam int SIW = $clog2(N_SEM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDW-1:0]   set_id,
  input  logic [SIW-1:0]   set_sem,
  input  logic             wake_en,
  input  logic [SIW-1:0]   wake_sem,
  output logic [N_REQ-1:0] asleep
);
  for (genvar g = 0; g < N_REQ; g++) begin : g_req
    logic           sleep_q;
    logic [SIW-1:0] sem_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        sleep_q <= 1'b0;
        sem_q   <= '0;
      end else if (set_en && set_id == IDW'(g)) begin
        sleep_q <= 1'b1;
        sem_q   <= set_sem;
      end else if (wake_en && sem_q == wake_sem) begin
        sleep_q <= 1'b0;
      end
    end

    assign asleep[g] = sleep_q;
  end
endmodule

// File: rtl/sem_wait_signal_unit.sv
module sem_wait_signal_unit #(
  parameter int N_REQ    = 4,
  parameter int N_SEM    = 4,
  parameter int CNT_W    = 4,
  parameter int INIT_CNT = 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [N_REQ-1:0]               req_valid,
  input  logic [N_REQ-1:0]               req_op,
  input  logic [N_REQ*$clog2(N_SEM)-1:0] req_sem,
  output logic [N_REQ-1:0]               ack,
  output logic [N_REQ-1:0]               granted
);
  import sem_unit_pkg::*;

  localparam int IDW = $clog2(N_REQ);
  localparam int SIW = $clog2(N_SEM);

  logic [N_REQ-1:0] asleep;
  logic [N_REQ-1:0] elig;
  logic             win_vld;
  logic [IDW-1:0]   win_id;
  sem_op_e          win_op;
  logic [SIW-1:0]   win_sem;
  logic             bank_ok;
  logic [N_REQ-1:0] ack_d, ok_d;
  logic [N_REQ-1:0] ack_q, ok_q;

  // sleepers and the requester acknowledged this cycle sit out
  assign elig = req_valid & ~asleep & ~ack_q;

  sem_rr_arbiter #(.N(N_REQ)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .elig    (elig),
    .win_vld (win_vld),
    .win_id  (win_id)
  );

  assign win_op  = sem_op_e'(req_op[win_id]);
  assign win_sem = req_sem[win_id*SIW +: SIW];

  sem_count_bank #(
    .N_SEM    (N_SEM),
    .CNT_W    (CNT_W),
    .INIT_CNT (INIT_CNT)
  ) u_bank (
    .clk    (clk),
    .rst    (rst),
    .op_en  (win_vld),
    .op_sig (win_op == OP_SIGNAL),
    .op_idx (win_sem),
    .op_ok  (bank_ok)
  );

  sem_sleep_tracker #(
    .N_REQ (N_REQ),
    .N_SEM (N_SEM)
  ) u_sleep (
    .clk      (clk),
    .rst      (rst),
    .set_en   (win_vld && win_op == OP_WAIT && !bank_ok),
    .set_id   (win_id),
    .set_sem  (win_sem),
    .wake_en  (win_vld && win_op == OP_SIGNAL),
    .wake_sem (win_sem),
    .asleep   (asleep)
  );

  always_comb begin
    ack_d = '0;
    ok_d  = '0;
    if (win_vld) begin
      ack_d[win_id] = 1'b1;
      ok_d[win_id]  = bank_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= '0;
      ok_q  <= '0;
    end else begin
      ack_q <= ack_d;
      ok_q  <= ok_d;
    end
  end

  assign ack     = ack_q;
  assign granted = ok_q;
endmodule

// File: rtl/sem_unit_chk.sv
module sem_unit_chk #(
  parameter int N_REQ = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [N_REQ-1:0] req_valid,
  input logic [N_REQ-1:0] ack,
  input logic [N_REQ-1:0] granted,
  input logic [N_REQ-1:0] asleep
);
  AST_ONE_ACK_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack)); // R7

  AST_ACK_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (rst)
    (ack & ~$past(req_valid)) == '0); // R7

  AST_REFUSAL_SLEEPS: assert property (@(posedge clk) disable iff (rst)
    ((ack & ~granted) & ~asleep) == '0); // R3

  AST_SLEEPER_NOT_SERVED: assert property (@(posedge clk) disable iff (rst)
    (asleep != '0) |=> ((ack & $past(asleep)) == '0)); // R4

  AST_ACK_IS_PULSE: assert property (@(posedge clk) disable iff (rst)
    (ack != '0) |=> ((ack & $past(ack)) == '0)); // R9

  AST_GRANT_ONLY_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    (granted & ~ack) == '0); // R9
endmodule

bind sem_wait_signal_unit sem_unit_chk #(.N_REQ(N_REQ)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .ack       (ack),
  .granted   (granted),
  .asleep    (asleep)
);

// File: tb/sem_wait_signal_unit_tb.sv
module sem_wait_signal_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 4;
  localparam int NS   = 4;
  localparam int CW   = 4;
  localparam int INIT = 1;
  localparam int SW   = $clog2(NS);
  localparam int MAXC = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req_valid = '0;
  logic [N-1:0]  req_op = '0;
  logic [N*SW-1:0] req_sem = '0;
  logic [N-1:0]  ack, granted;

  sem_wait_signal_unit #(.N_REQ(N), .N_SEM(NS), .CNT_W(CW), .INIT_CNT(INIT)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_sem(req_sem), .ack(ack), .granted(granted)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // reference state, built from the requirements
  int       m_cnt [NS];
  bit       m_sleep [N];
  int       m_ssem [N];
  int       m_ptr;
  logic [N-1:0] exp_ack, exp_ok, ack_prev, last_ack;
  string    exp_tag;
  string    phase;
  bit       hold_after_ack;
  bit       random_fill;
  int       n_checks, n_fail, cycles;

  task automatic chk(bit cond, string tag, string what, int act, int expv);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic predict();
    int win;
    int s;
    win = -1;
    exp_ack = '0;
    exp_ok  = '0;
    exp_tag = phase;
    for (int i = 0; i < N; i++) begin
      int j;
      j = (m_ptr + i) % N;
      if (win < 0 && req_valid[j] && !m_sleep[j] && !ack_prev[j]) win = j;
    end
    if (win >= 0) begin
      exp_ack[win] = 1'b1;
      m_ptr = (win + 1) % N;
      s = int'(req_sem[win*SW +: SW]);
      if (req_op[win]) begin
        if (m_cnt[s] < MAXC) m_cnt[s]++;
        exp_ok[win] = 1'b1;
        for (int k = 0; k < N; k++) if (m_sleep[k] && m_ssem[k] == s) m_sleep[k] = 1'b0;
        exp_tag = {phase, "/R5"};
      end else if (m_cnt[s] > 0) begin
        m_cnt[s]--;
        exp_ok[win] = 1'b1;
        exp_tag = {phase, "/R2"};
      end else begin
        m_sleep[win] = 1'b1;
        m_ssem[win] = s;
        exp_tag = {phase, "/R3"};
      end
    end
  endtask

  task automatic step();
    if (random_fill) begin
      for (int r = 0; r < N; r++) begin
        if (!req_valid[r] && ($urandom % 2) == 1) begin
          req_valid[r] = 1'b1;
          req_op[r] = 1'($urandom % 2);
          req_sem[r*SW +: SW] = SW'($urandom % NS);
        end
      end
    end
    predict();
    @(posedge clk);
    @(negedge clk);
    chk(ack == exp_ack, exp_tag, "ack R8", int'(ack), int'(exp_ack));
    chk(granted == exp_ok, exp_tag, "granted", int'(granted), int'(exp_ok));
    ack_prev = exp_ack;
    last_ack = exp_ack;
    for (int r = 0; r < N; r++) begin
      if (exp_ack[r] && !hold_after_ack && (exp_ok[r] || req_op[r])) req_valid[r] = 1'b0;
    end
  endtask

  task automatic issue(int r, bit op, int s);
    req_valid[r] = 1'b1;
    req_op[r] = op;
    req_sem[r*SW +: SW] = SW'(s);
    for (int t = 0; t < 6; t++) begin
      step();
      if (last_ack[r]) break;
    end
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    n_checks = 0; n_fail = 0;
    for (int s = 0; s < NS; s++) m_cnt[s] = INIT;
    for (int r = 0; r < N; r++) begin m_sleep[r] = 1'b0; m_ssem[r] = 0; end
    m_ptr = 0; ack_prev = '0; last_ack = '0;
    hold_after_ack = 1'b0; random_fill = 1'b0;
    phase = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(ack == '0, "R1", "ack after reset", int'(ack), 0);
    chk(granted == '0, "R1", "granted after reset", int'(granted), 0);
    repeat (2) step();

    // R2: first WAIT on an initialised count is granted
    phase = "R2";
    issue(0, 1'b0, 0);

    // R3: two more WAITs on the now empty count are refused
    phase = "R3";
    req_valid[1] = 1'b1; req_op[1] = 1'b0; req_sem[1*SW +: SW] = SW'(0);
    req_valid[2] = 1'b1; req_op[2] = 1'b0; req_sem[2*SW +: SW] = SW'(0);
    step(); step();

    // R4: sleepers keep requesting and stay ignored; another requester still runs
    phase = "R4";
    repeat (3) step();
    issue(3, 1'b0, 1);
    repeat (2) step();

    // R5: SIGNAL on another semaphore wakes nobody, then SIGNAL on 0 wakes both
    phase = "R5";
    issue(0, 1'b1, 1);
    repeat (3) step();
    // R8: woken requesters retry in ring order; the later one sleeps again
    phase = "R8";
    issue(0, 1'b1, 0);
    repeat (4) step();
    issue(3, 1'b1, 0);
    repeat (3) step();

    // R8: all requesters SIGNAL at once, served in ring order
    for (int r = 0; r < N; r++) begin
      req_valid[r] = 1'b1; req_op[r] = 1'b1; req_sem[r*SW +: SW] = SW'(2);
    end
    repeat (6) step();

    // R6: saturate one count, then drain it until a WAIT is refused
    phase = "R6";
    for (int k = 0; k < MAXC + 3; k++) issue(0, 1'b1, 3);
    for (int k = 0; k < MAXC + 1; k++) issue(1, 1'b0, 3);
    issue(0, 1'b1, 3);
    repeat (3) step();

    // R9: a request held high after its ack sits out exactly one cycle
    phase = "R9";
    hold_after_ack = 1'b1;
    req_valid[2] = 1'b1; req_op[2] = 1'b0; req_sem[2*SW +: SW] = SW'(2);
    repeat (5) step();
    hold_after_ack = 1'b0;
    req_valid = '0;
    repeat (2) step();

    // R7: random mix from all requesters
    phase = "R7";
    random_fill = 1'b1;
    repeat (3000) step();
    random_fill = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule